// File: doc/BRIEF.md
# Two-Bank Interleaved State-Update Unit

This block is a near-memory compute engine that serves a pair of DRAM banks whose rows are already open. On a start command it walks the columns of both open rows. Each column holds a state sub-chunk, a vector of signed 8-bit elements. The unit reads each sub-chunk, updates every element with a fixed-point multiply-add, and writes the result back to the column it came from.

The two banks share one pipeline. Reads alternate between them every unit cycle, and the pipeline latency is odd. As a result, the write-back to one bank always falls in a slot where the other bank is being read. Both row buffers stay busy, and no row buffer has to serve a read and a write in the same slot.

Operands live in registers loaded through a byte-wide port. A decay vector and a key vector are shared by both banks and are loaded once per group of chunks. Each bank also has its own v vector with one element per column, which is reloaded for every chunk. The operands keep their values across runs, so later chunks of a group need only new v values.

Top module: `bank_pair_update_unit`

## Requirements
- R1: During and straight after reset, busy and done are low and none of the four bank strobes (b0_rd, b0_wr, b1_rd, b1_wr) is asserted.
- R2: Once a start is accepted with N columns, reads begin in the next cycle and alternate banks every cycle in ascending column order. Bank 0 column k is read in cycle 2k and bank 1 column k in cycle 2k+1, counting from 0. At most one bank is read per cycle.
- R3: Every column read is written back exactly once, to the same bank and the same column, exactly three cycles after its read.
- R4: No bank sees a read and a write in the same cycle. While reads remain, a write of bank 0 column k coincides with the read of bank 1 column k+1, and a write of bank 1 column k coincides with the read of bank 0 column k+2.
- R5: Element j of a column occupies data bits [8j+7:8j] as a two's-complement byte. Its new value is (decay[j]*s + key[j]*v) shifted right arithmetically by 4 (rounding toward minus infinity), then saturated to [-128, 127].
- R6: The v used for a column is the element of that bank's v vector whose index equals the column number. Load encodings: ld_sel 0 writes decay[ld_idx], 1 writes key[ld_idx], 2 writes bank 0 v[ld_idx], 3 writes bank 1 v[ld_idx].
- R7: done rises in the cycle after the last write-back, which is the (2N+4)th cycle after the start was sampled. busy falls at the same time. done then holds until the next accepted start.
- R8: A start with a column count of 0 is ignored, and busy and done keep their values. A count above MAX_COLS is clamped to MAX_COLS. Columns at index N and above are left untouched.
- R9: While busy, start commands and operand loads are ignored. They change neither the timing nor the results of the run in progress.
- R10: Operand registers keep their contents across runs. A run that follows a reload of only the v vectors uses the earlier decay and key values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock, one column slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| start | input | 1 | Start a run over both open rows |
| start_cols | input | CW+1 (4) | Columns per row for the run |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last write-back issued; held until next start |
| ld_en | input | 1 | Operand load strobe |
| ld_sel | input | 2 | Operand target (decay, key, v bank 0, v bank 1) |
| ld_idx | input | IW (3) | Element or column index of the load |
| ld_data | input | EW (8) | Signed operand byte |
| b0_rd | output | 1 | Bank 0 column read |
| b0_wr | output | 1 | Bank 0 column write |
| b0_col | output | CW (3) | Bank 0 column address |
| b0_wdata | output | DW (32) | Bank 0 write data |
| b0_rdata | input | DW (32) | Bank 0 read data, valid the cycle after b0_rd |
| b1_rd | output | 1 | Bank 1 column read |
| b1_wr | output | 1 | Bank 1 column write |
| b1_col | output | CW (3) | Bank 1 column address |
| b1_wdata | output | DW (32) | Bank 1 write data |
| b1_rdata | input | DW (32) | Bank 1 read data, valid the cycle after b1_rd |

## Verification
A wrong pipeline tag, such as the bank bit or column carried alongside the data, shows up three cycles after the faulty read as a write to the wrong bank or column. The monitor catches it at that write, long before the final contents are compared. Arithmetic faults in the lanes, the shift or the saturation land in the column's stored word at the same write-back. Random sweeps and extreme operands together make sure sign, rounding and clamping faults change at least one compared word. A scheduler fault that stalls, skips or repeats a column changes the write count and the start-to-done cycle count, both of which are checked on every run.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FIN   = 2'd3
  } sup_state_e;

  typedef enum logic [1:0] {
    OP_DECAY = 2'd0,
    OP_KEY   = 2'd1,
    OP_V0    = 2'd2,
    OP_V1    = 2'd3
  } sup_op_e;
endpackage

// File: rtl/sup_sched.sv
module sup_sched
  import sup_pkg::*;
#(
  parameter int MAX_COLS = 8,
  parameter int CW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW:0]   start_cols,
  input  logic          tail,
  output logic          busy,
  output logic          done,
  output logic          rd_vld,
  output logic          rd_bank,
  output logic [CW-1:0] rd_col
);
  sup_state_e    state_q, state_d;
  logic [CW:0]   idx_q, idx_d;
  logic          idx_en;
  logic [CW-1:0] nm1_q, nm1_d, nm1_lim;
  logic          nm1_en;
  logic          start_ok;

  // next-state process
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    idx_en   = 1'b0;
    nm1_d    = nm1_q;
    nm1_en   = 1'b0;
    start_ok = start && (start_cols != '0);
    if (start_cols > (CW+1)'(MAX_COLS)) nm1_lim = CW'(MAX_COLS - 1);
    else                                nm1_lim = CW'(start_cols - 1'b1);
    case (state_q)
      ST_IDLE, ST_FIN: begin
        if (start_ok) begin
          state_d = ST_ISSUE;
          idx_d   = '0;
          idx_en  = 1'b1;
          nm1_d   = nm1_lim;
          nm1_en  = 1'b1;
        end
      end
      ST_ISSUE: begin
        if (idx_q == {nm1_q, 1'b1}) begin
          state_d = ST_DRAIN;
        end else begin
          idx_d  = idx_q + 1'b1;
          idx_en = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (tail) state_d = ST_FIN;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      nm1_q   <= '0;
    end else begin
      state_q <= state_d;
      if (idx_en) idx_q <= idx_d;
      if (nm1_en) nm1_q <= nm1_d;
    end
  end

  assign rd_vld  = (state_q == ST_ISSUE);
  assign rd_bank = idx_q[0];
  assign rd_col  = idx_q[CW:1];
  assign busy    = (state_q == ST_ISSUE) || (state_q == ST_DRAIN);
  assign done    = (state_q == ST_FIN);

  // R2
  rd_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && $past(rd_vld)) |-> (rd_bank != $past(rd_bank)));

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ISSUE && start) |=> (idx_q != '0));
endmodule

// File: rtl/sup_opregs.sv
module sup_opregs
  import sup_pkg::*;
#(
  parameter int ELEMS    = 4,
  parameter int EW       = 8,
  parameter int MAX_COLS = 8,
  parameter int IW       = 3
) (
  input  logic                          clk,
  input  logic                          busy,
  input  logic                          ld_en,
  input  logic [1:0]                    ld_sel,
  input  logic [IW-1:0]                 ld_idx,
  input  logic [EW-1:0]                 ld_data,
  output logic [ELEMS-1:0][EW-1:0]      decay_o,
  output logic [ELEMS-1:0][EW-1:0]      key_o,
  output logic [MAX_COLS-1:0][EW-1:0]   v0_o,
  output logic [MAX_COLS-1:0][EW-1:0]   v1_o
);
  logic ld_ok;
  assign ld_ok = ld_en && !busy;

  for (genvar j = 0; j < ELEMS; j++) begin : g_elem
    logic dec_en, key_en;
    always_comb begin
      dec_en = ld_ok && (ld_sel == OP_DECAY) && (ld_idx == IW'(j));
      key_en = ld_ok && (ld_sel == OP_KEY)   && (ld_idx == IW'(j));
    end
    always_ff @(posedge clk) begin
      if (dec_en) decay_o[j] <= ld_data;
      if (key_en) key_o[j]   <= ld_data;
    end
  end

  for (genvar c = 0; c < MAX_COLS; c++) begin : g_col
    logic v0_en, v1_en;
    always_comb begin
      v0_en = ld_ok && (ld_sel == OP_V0) && (ld_idx == IW'(c));
      v1_en = ld_ok && (ld_sel == OP_V1) && (ld_idx == IW'(c));
    end
    always_ff @(posedge clk) begin
      if (v0_en) v0_o[c] <= ld_data;
      if (v1_en) v1_o[c] <= ld_data;
    end
  end
endmodule

// File: rtl/sup_mac_lane.sv
module sup_mac_lane #(
  parameter int EW = 8,
  localparam int SW = 2*EW + 1
) (
  input  logic signed [EW-1:0] state_i,
  input  logic signed [EW-1:0] decay_i,
  input  logic signed [EW-1:0] key_i,
  input  logic signed [EW-1:0] vel_i,
  output logic        [SW-1:0] sum_o
);
  logic signed [2*EW-1:0] prod_s, prod_k;
  assign prod_s = state_i * decay_i;
  assign prod_k = key_i * vel_i;
  assign sum_o  = {prod_s[2*EW-1], prod_s} + {prod_k[2*EW-1], prod_k};
endmodule

// File: rtl/sup_sat.sv
module sup_sat #(
  parameter int EW   = 8,
  parameter int FRAC = 4,
  localparam int SW  = 2*EW + 1
) (
  input  logic signed [SW-1:0] sum_i,
  output logic        [EW-1:0] res_o
);
  localparam logic signed [SW-1:0] HI = SW'((2**(EW-1)) - 1);
  localparam logic signed [SW-1:0] LO = ~HI;
  logic signed [SW-1:0] sh;
  assign sh = sum_i >>> FRAC;
  always_comb begin
    if (sh > HI)      res_o = HI[EW-1:0];
    else if (sh < LO) res_o = LO[EW-1:0];
    else              res_o = sh[EW-1:0];
  end
endmodule

// File: rtl/bank_pair_update_unit.sv
module bank_pair_update_unit
  import sup_pkg::*;
#(
  parameter int ELEMS    = 4,
  parameter int EW       = 8,
  parameter int MAX_COLS = 8,
  parameter int FRAC     = 4,
  localparam int DW = ELEMS * EW,
  localparam int CW = $clog2(MAX_COLS),
  localparam int IW = (CW > $clog2(ELEMS)) ? CW : $clog2(ELEMS),
  localparam int SW = 2*EW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW:0]   start_cols,
  output logic          busy,
  output logic          done,
  input  logic          ld_en,
  input  logic [1:0]    ld_sel,
  input  logic [IW-1:0] ld_idx,
  input  logic [EW-1:0] ld_data,
  output logic          b0_rd,
  output logic          b0_wr,
  output logic [CW-1:0] b0_col,
  output logic [DW-1:0] b0_wdata,
  input  logic [DW-1:0] b0_rdata,
  output logic          b1_rd,
  output logic          b1_wr,
  output logic [CW-1:0] b1_col,
  output logic [DW-1:0] b1_wdata,
  input  logic [DW-1:0] b1_rdata
);
  logic          rd_vld, rd_bank, tail;
  logic [CW-1:0] rd_col;

  logic [ELEMS-1:0][EW-1:0]    dec_vec, key_vec;
  logic [MAX_COLS-1:0][EW-1:0] v0_vec, v1_vec;

  // pipeline stage registers: p0 read tag, p1 sums, p2 saturated words
  logic          p0_vld_q, p0_bank_q;
  logic [CW-1:0] p0_col_q;
  logic          p1_vld_q, p1_bank_q;
  logic [CW-1:0] p1_col_q;
  logic [ELEMS-1:0][SW-1:0] p1_sum_q;
  logic          p2_vld_q, p2_bank_q;
  logic [CW-1:0] p2_col_q;
  logic [DW-1:0] p2_data_q;

  logic [DW-1:0]            st_vec;
  logic [EW-1:0]            v_sel;
  logic [ELEMS-1:0][SW-1:0] sum_w;
  logic [DW-1:0]            res_w;

  sup_sched #(.MAX_COLS(MAX_COLS), .CW(CW)) u_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .start_cols(start_cols),
    .tail(tail), .busy(busy), .done(done),
    .rd_vld(rd_vld), .rd_bank(rd_bank), .rd_col(rd_col)
  );

  sup_opregs #(.ELEMS(ELEMS), .EW(EW), .MAX_COLS(MAX_COLS), .IW(IW)) u_ops (
    .clk(clk), .busy(busy), .ld_en(ld_en), .ld_sel(ld_sel),
    .ld_idx(ld_idx), .ld_data(ld_data),
    .decay_o(dec_vec), .key_o(key_vec), .v0_o(v0_vec), .v1_o(v1_vec)
  );

  // stage 1 operand selection
  always_comb begin
    st_vec = p0_bank_q ? b1_rdata : b0_rdata;
    v_sel  = p0_bank_q ? v1_vec[p0_col_q] : v0_vec[p0_col_q];
  end

  for (genvar j = 0; j < ELEMS; j++) begin : g_lane
    sup_mac_lane #(.EW(EW)) u_mac (
      .state_i(st_vec[j*EW +: EW]), .decay_i(dec_vec[j]), .key_i(key_vec[j]),
      .vel_i(v_sel), .sum_o(sum_w[j])
    );
    sup_sat #(.EW(EW), .FRAC(FRAC)) u_sat (
      .sum_i(p1_sum_q[j]), .res_o(res_w[j*EW +: EW])
    );
  end

  // valid chain, reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p0_vld_q <= 1'b0;
      p1_vld_q <= 1'b0;
      p2_vld_q <= 1'b0;
    end else begin
      p0_vld_q <= rd_vld;
      p1_vld_q <= p0_vld_q;
      p2_vld_q <= p1_vld_q;
    end
  end

  // tag and data flops, enabled, no reset
  always_ff @(posedge clk) begin
    if (rd_vld) begin
      p0_bank_q <= rd_bank;
      p0_col_q  <= rd_col;
    end
    if (p0_vld_q) begin
      p1_bank_q <= p0_bank_q;
      p1_col_q  <= p0_col_q;
      p1_sum_q  <= sum_w;
    end
    if (p1_vld_q) begin
      p2_bank_q <= p1_bank_q;
      p2_col_q  <= p1_col_q;
      p2_data_q <= res_w;
    end
  end

  assign tail     = p2_vld_q && !p1_vld_q && !p0_vld_q;
  assign b0_rd    = rd_vld && !rd_bank;
  assign b1_rd    = rd_vld && rd_bank;
  assign b0_wr    = p2_vld_q && !p2_bank_q;
  assign b1_wr    = p2_vld_q && p2_bank_q;
  assign b0_col   = b0_rd ? rd_col : p2_col_q;
  assign b1_col   = b1_rd ? rd_col : p2_col_q;
  assign b0_wdata = p2_data_q;
  assign b1_wdata = p2_data_q;

  // R4
  b0_clash_chk: assert property (@(posedge clk) disable iff (!rst_n) !(b0_rd && b0_wr));
  // R4
  b1_clash_chk: assert property (@(posedge clk) disable iff (!rst_n) !(b1_rd && b1_wr));
  // R3
  b0_wb_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b0_wr |-> ($past(b0_rd, 3) && b0_col == $past(b0_col, 3)));
  // R3
  b1_wb_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b1_wr |-> ($past(b1_rd, 3) && b1_col == $past(b1_col, 3)));
  // R2
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({b0_rd, b1_rd}) <= 1);
  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(b0_rd || b0_wr || b1_rd || b1_wr));
endmodule

// File: tb/tb_bank_pair_update_unit.sv
`timescale 1ns/1ps
module tb_bank_pair_update_unit;
  localparam int NC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] start_cols = '0;
  logic busy, done;
  logic ld_en = 1'b0;
  logic [1:0] ld_sel = '0;
  logic [2:0] ld_idx = '0;
  logic [7:0] ld_data = '0;
  logic b0_rd, b0_wr, b1_rd, b1_wr;
  logic [2:0] b0_col, b1_col;
  logic [31:0] b0_wdata, b1_wdata;
  logic [31:0] b0_rdata = '0, b1_rdata = '0;

  always #2.5 clk = ~clk;

  bank_pair_update_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_cols(start_cols),
    .busy(busy), .done(done), .ld_en(ld_en), .ld_sel(ld_sel), .ld_idx(ld_idx),
    .ld_data(ld_data), .b0_rd(b0_rd), .b0_wr(b0_wr), .b0_col(b0_col),
    .b0_wdata(b0_wdata), .b0_rdata(b0_rdata), .b1_rd(b1_rd), .b1_wr(b1_wr),
    .b1_col(b1_col), .b1_wdata(b1_wdata), .b1_rdata(b1_rdata)
  );

  logic [31:0] mem0 [NC], mem1 [NC], ini0 [NC], ini1 [NC];
  int dec [4], key [4], v0 [NC], v1 [NC];
  int n_chk = 0, n_fail = 0;
  int cyc = 0, run_n = 0, wcnt0 = 0, wcnt1 = 0;
  int rc0 [NC], rc1 [NC];
  bit [31:0] seed = 32'h1234_5678;

  // bank model: registered read, write at the edge
  always @(posedge clk) begin
    if (b0_rd) b0_rdata <= mem0[b0_col];
    if (b1_rd) b1_rdata <= mem1[b1_col];
    if (b0_wr) mem0[b0_col] <= b0_wdata;
    if (b1_wr) mem1[b1_col] <= b1_wdata;
  end

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", rq, act, exp, $time);
    end
  endtask

  function automatic int rnd8();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'($signed(seed[23:16]));
  endfunction

  function automatic int upd(input int s, input int d, input int k, input int v);
    int t;
    t = d*s + k*v;
    t = t >>> 4;
    if (t > 127) t = 127;
    if (t < -128) t = -128;
    return t;
  endfunction

  // monitor away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (b0_rd) rc0[b0_col] = cyc;
      if (b1_rd) rc1[b1_col] = cyc;
      if (b0_wr) begin
        wcnt0++;
        chk(cyc - rc0[b0_col] == 3, "R3 b0 write delay", cyc - rc0[b0_col], 3);
        chk(!b0_rd, "R4 b0 rd/wr clash", b0_rd, 0);
        if (int'(b0_col) < run_n - 1)
          chk(b1_rd && b1_col == b0_col + 3'd1, "R4 b0 write overlap", b1_col, b0_col + 1);
      end
      if (b1_wr) begin
        wcnt1++;
        chk(cyc - rc1[b1_col] == 3, "R3 b1 write delay", cyc - rc1[b1_col], 3);
        chk(!b1_rd, "R4 b1 rd/wr clash", b1_rd, 0);
        if (int'(b1_col) + 2 < run_n)
          chk(b0_rd && b0_col == b1_col + 3'd2, "R4 b1 write overlap", b0_col, b1_col + 2);
      end
    end
  end

  task automatic ld(input int sel, input int idx, input int val);
    ld_en = 1'b1; ld_sel = sel[1:0]; ld_idx = idx[2:0]; ld_data = val[7:0];
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load_shared();
    for (int j = 0; j < 4; j++) ld(0, j, dec[j]);
    for (int j = 0; j < 4; j++) ld(1, j, key[j]);
  endtask

  task automatic load_v();
    for (int c = 0; c < NC; c++) ld(2, c, v0[c]);
    for (int c = 0; c < NC; c++) ld(3, c, v1[c]);
  endtask

  task automatic fill_rand();
    for (int c = 0; c < NC; c++) begin
      for (int j = 0; j < 4; j++) begin
        mem0[c][j*8 +: 8] = 8'(rnd8());
        mem1[c][j*8 +: 8] = 8'(rnd8());
      end
    end
  endtask

  task automatic run(input int cols_in, input bit disturb);
    int n, k;
    logic [31:0] e;
    n = (cols_in > NC) ? NC : cols_in;
    run_n = n; wcnt0 = 0; wcnt1 = 0;
    for (int c = 0; c < NC; c++) begin ini0[c] = mem0[c]; ini1[c] = mem1[c]; end
    start = 1'b1; start_cols = cols_in[3:0];
    @(negedge clk);
    start = 1'b0;
    k = 1;
    chk(b0_rd && b0_col == 3'd0 && !b1_rd, "R2 first read", b0_col, 0);
    while (!done && k < 200) begin
      if (disturb && k == 3) begin
        ld_en = 1'b1; ld_sel = 2'd0; ld_idx = 3'd0; ld_data = 8'h63;
        start = 1'b1; start_cols = 4'd2;
      end
      @(negedge clk);
      ld_en = 1'b0; start = 1'b0;
      k++;
    end
    chk(k < 200, "R7 watchdog", k, 2*n + 4);
    chk(k == 2*n + 4, "R7 start-to-done cycles", k, 2*n + 4);
    chk(!busy && done, "R7 busy/done", busy, 0);
    chk(wcnt0 == n && wcnt1 == n, "R3 write count", wcnt0 + wcnt1, 2*n);
    for (int c = 0; c < NC; c++) begin
      for (int b = 0; b < 2; b++) begin
        for (int j = 0; j < 4; j++) begin
          int s;
          s = int'($signed(b ? ini1[c][j*8 +: 8] : ini0[c][j*8 +: 8]));
          e[j*8 +: 8] = (c < n) ? 8'(upd(s, dec[j], key[j], b ? v1[c] : v0[c])) : 8'(s);
        end
        if (b == 0) chk(mem0[c] == e, (c < n) ? "R5/R6 bank0 word" : "R8 bank0 untouched", mem0[c], e);
        else        chk(mem1[c] == e, (c < n) ? "R5/R6 bank1 word" : "R8 bank1 untouched", mem1[c], e);
      end
    end
  endtask

  task automatic rand_ops();
    for (int j = 0; j < 4; j++) begin dec[j] = rnd8(); key[j] = rnd8(); end
    for (int c = 0; c < NC; c++) begin v0[c] = rnd8(); v1[c] = rnd8(); end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(!busy && !done && !b0_rd && !b0_wr && !b1_rd && !b1_wr, "R1 reset state", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !b0_rd && !b0_wr && !b1_rd && !b1_wr, "R1 after reset", done, 0);

    // R5 identity: decay 1.0 in Q4, key 0
    for (int j = 0; j < 4; j++) begin dec[j] = 16; key[j] = 0; end
    for (int c = 0; c < NC; c++) begin v0[c] = c * 9 - 30; v1[c] = 50 - c * 7; end
    load_shared(); load_v(); fill_rand();
    run(8, 1'b0);

    // R5 saturation extremes
    dec[0] = 127; dec[1] = -128; dec[2] = 127; dec[3] = -128;
    key[0] = 127; key[1] = 127; key[2] = -128; key[3] = -128;
    for (int c = 0; c < NC; c++) begin v0[c] = (c % 2) ? 127 : -128; v1[c] = (c % 3) - 1; end
    for (int c = 0; c < NC; c++) begin
      mem0[c] = (c % 2) ? 32'h7f80_7f80 : 32'h807f_807f;
      mem1[c] = {8'(c * 37), 8'h80, 8'h7f, 8'(-c)};
    end
    load_shared(); load_v();
    run(8, 1'b0);

    // R6 / R8 random sweep over column counts
    for (int r = 0; r < 8; r++) begin
      rand_ops(); load_shared(); load_v(); fill_rand();
      run(r + 1, 1'b0);
    end

    // R10 reload only v, shared operands kept
    for (int c = 0; c < NC; c++) begin v0[c] = rnd8(); v1[c] = rnd8(); end
    load_v(); fill_rand();
    run(5, 1'b0);

    // R9 loads and start during busy ignored
    rand_ops(); load_shared(); load_v(); fill_rand();
    run(6, 1'b1);

    // R8 zero count ignored
    start = 1'b1; start_cols = 4'd0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(!busy && done && !b0_rd && !b1_rd, "R8 zero count ignored", busy, 0);

    // R8 clamp above maximum
    rand_ops(); load_shared(); load_v(); fill_rand();
    run(15, 1'b0);

    summary();
    $finish;
  end
endmodule